// File: doc/BRIEF.md
# Lease-Timestamp L2 Bank with Adaptive Lifetime

This block is one bank of a shared second-level cache for a many-core accelerator in which private first-level copies are never tracked by a sharer list. For each block, the bank instead keeps one timestamp: the latest expiry it has granted to any first-level copy. Time is a free-running global count supplied on an input pin. Once a block's timestamp is behind global time, no first-level cache can still hold a live copy of that block.

A load is granted a lease that lasts from the current global time until that time plus a predicted lifetime. The block's timestamp is raised to that expiry if the expiry is later. A store is never held back by live leases. Its data lands in the array at once, and the response carries the time at which the write becomes visible everywhere, meaning the moment the last live lease runs out. An evict request drops lease tracking for a block and completes at once; no recall is issued.

A single saturating lifetime value per bank adapts the lease length. It grows when a load finds its block's lease already lapsed, and it shrinks when a store or an evict hits a block that still has a live lease. Requests and responses use valid/ready handshakes. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next edge and is held unchanged until `rsp_ready` is seen high. `req_ready` is low only while an undelivered response is being held back, so back-pressure on the response side stalls the request side with no gap and no loss.

Top module: `lease_l2_bank`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, every block timestamp is 0, all data is 0 and the lifetime value is 16.
- R2: A load (`req_op`=0) accepted at global time G answers with `rsp_time` = G + P, where P is the lifetime value when the load is accepted, and with `rsp_data` = the block's stored data.
- R3: After a load, the block timestamp is the larger of its old value and the granted expiry, so a shorter grant never lowers it.
- R4: A store (`req_op`=1) is accepted even when its block has a live lease, and its data is returned by any later load of that address.
- R5: A store's `rsp_time` is the block timestamp when that timestamp is live, and G otherwise; the store does not change the timestamp.
- R6: A load whose block timestamp is below G raises the lifetime value by one; a load of a live block leaves it unchanged.
- R7: A store to a live block lowers the lifetime value by one; a store to a lapsed block leaves it unchanged.
- R8: An evict (`req_op`=2) returns the stored data, reports `rsp_time` under the same rule as a store, clears the block timestamp to 0, and lowers the lifetime value by one only if the block was live.
- R9: The lifetime value stays within 1 to 255 inclusive, saturating at either end.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold steady and `req_ready` is 0.
- R11: A block whose timestamp equals G counts as live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gtime | input | TS_W | Global time count |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_op | input | 2 | 0 load, 1 store, 2 evict |
| req_addr | input | ADDR_W | Block index |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_op | output | 2 | Operation being answered |
| rsp_data | output | DATA_W | Block data (load and evict) |
| rsp_time | output | TS_W | Lease expiry (load) or completion time (store, evict) |

## Verification
Every response becomes valid on the first clock edge after the edge that accepts its request, because the response register is the only stage. Changes to the lifetime value and to the timestamp take effect on that same edge, so they shape the very next request. The driver computes each expected response from a software model, using the global time and the lifetime value at the point of acceptance, and pushes it into a queue. The monitor compares each response against that queue on falling edges, but only when valid and ready are both high. This ties results to handshakes rather than fixed delays, so stalled responses are still checked exactly once.

// File: rtl/lease_l2_pkg.sv
package lease_l2_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2
  } lease_op_e;
endpackage

// File: rtl/lease_predictor.sv
module lease_predictor #(
  parameter int PRED_W    = 8,
  parameter int PRED_MIN  = 1,
  parameter int PRED_MAX  = 255,
  parameter int PRED_INIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [PRED_W-1:0] pred
);
  localparam logic [PRED_W-1:0] LO   = PRED_W'(PRED_MIN);
  localparam logic [PRED_W-1:0] HI   = PRED_W'(PRED_MAX);
  localparam logic [PRED_W-1:0] INIT = PRED_W'(PRED_INIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred <= INIT;
    end else if (inc && !dec) begin
      if (pred < HI) pred <= pred + 1'b1;
    end else if (dec && !inc) begin
      if (pred > LO) pred <= pred - 1'b1;
    end
  end

  // R9
  pred_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred >= LO) && (pred <= HI));
  // R6
  pred_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && pred < HI) |=> pred == $past(pred) + 1'b1);
  // R7
  pred_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && pred > LO) |=> pred == $past(pred) - 1'b1);
endmodule

// File: rtl/lease_block_store.sv
module lease_block_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [TS_W-1:0]   rd_ts,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ts_we,
  input  logic [TS_W-1:0]   ts_wdata,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata
);
  localparam int NUM_BLOCKS = 1 << ADDR_W;

  logic [TS_W-1:0]   ts_q   [NUM_BLOCKS];
  logic [DATA_W-1:0] data_q [NUM_BLOCKS];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic hit;
    assign hit = (addr == ADDR_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ts_q[b]   <= '0;
        data_q[b] <= '0;
      end else begin
        if (ts_we && hit)   ts_q[b]   <= ts_wdata;
        if (data_we && hit) data_q[b] <= data_wdata;
      end
    end
  end

  assign rd_ts   = ts_q[addr];
  assign rd_data = data_q[addr];
endmodule

// File: rtl/lease_classify.sv
module lease_classify
  import lease_l2_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int PRED_W = 8
) (
  input  logic              fire,
  input  lease_op_e         op,
  input  logic [TS_W-1:0]   blk_ts,
  input  logic [TS_W-1:0]   gtime,
  input  logic [PRED_W-1:0] pred,
  output logic              ts_we,
  output logic [TS_W-1:0]   ts_new,
  output logic              data_we,
  output logic              pred_inc,
  output logic              pred_dec,
  output logic [TS_W-1:0]   resp_time
);
  logic            live;
  logic [TS_W-1:0] grant;

  assign live  = (blk_ts >= gtime);
  assign grant = gtime + TS_W'(pred);

  always_comb begin
    ts_we     = 1'b0;
    ts_new    = blk_ts;
    data_we   = 1'b0;
    pred_inc  = 1'b0;
    pred_dec  = 1'b0;
    resp_time = live ? blk_ts : gtime;
    if (fire) begin
      unique case (op)
        OP_LOAD: begin
          ts_we     = 1'b1;
          ts_new    = (grant > blk_ts) ? grant : blk_ts;
          pred_inc  = !live;
          resp_time = grant;
        end
        OP_STORE: begin
          data_we  = 1'b1;
          pred_dec = live;
        end
        OP_EVICT: begin
          ts_we    = 1'b1;
          ts_new   = '0;
          pred_dec = live;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lease_l2_bank.sv
module lease_l2_bank
  import lease_l2_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int TS_W      = 32,
  parameter int PRED_W    = 8,
  parameter int PRED_MIN  = 1,
  parameter int PRED_MAX  = 255,
  parameter int PRED_INIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   gtime,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_op,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TS_W-1:0]   rsp_time
);
  logic              fire;
  lease_op_e         op;
  logic [TS_W-1:0]   blk_ts;
  logic [DATA_W-1:0] blk_data;
  logic [PRED_W-1:0] pred;
  logic              ts_we, data_we, pred_inc, pred_dec;
  logic [TS_W-1:0]   ts_new, resp_time;

  assign op        = lease_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  lease_block_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(req_addr),
    .rd_ts(blk_ts), .rd_data(blk_data),
    .ts_we(ts_we), .ts_wdata(ts_new),
    .data_we(data_we), .data_wdata(req_wdata)
  );

  lease_classify #(.TS_W(TS_W), .PRED_W(PRED_W)) u_cls (
    .fire(fire), .op(op), .blk_ts(blk_ts), .gtime(gtime), .pred(pred),
    .ts_we(ts_we), .ts_new(ts_new), .data_we(data_we),
    .pred_inc(pred_inc), .pred_dec(pred_dec), .resp_time(resp_time)
  );

  lease_predictor #(.PRED_W(PRED_W), .PRED_MIN(PRED_MIN), .PRED_MAX(PRED_MAX),
                    .PRED_INIT(PRED_INIT)) u_pred (
    .clk(clk), .rst_n(rst_n), .inc(pred_inc), .dec(pred_dec), .pred(pred)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_op    <= '0;
      rsp_data  <= '0;
      rsp_time  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_op    <= req_op;
      rsp_data  <= blk_data;
      rsp_time  <= resp_time;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_time) && $stable(rsp_data));
  // R5
  store_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd1) |=> rsp_time >= $past(gtime));
  // R2
  load_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0) |=> rsp_time > $past(gtime));
endmodule

// File: tb/lease_l2_bank_tb.sv
module lease_l2_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] gtime = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_op;
  logic [31:0] rsp_data;
  logic [31:0] rsp_time;

  always #2.5 clk = ~clk;

  lease_l2_bank u_dut (
    .clk(clk), .rst_n(rst_n), .gtime(gtime),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op),
    .rsp_data(rsp_data), .rsp_time(rsp_time)
  );

  typedef struct {
    logic [1:0]  op;
    logic [31:0] data;
    logic [31:0] tm;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] ts_m  [16];
  logic [31:0] mem_m [16];
  int          pred_m = 16;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: model the request at acceptance, push the expected response.
  task automatic issue(input logic [1:0] op, input int addr, input logic [31:0] wd,
                       input logic [31:0] gt, input string tag);
    exp_t e;
    bit   live;
    gtime     = gt;
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = 4'(addr);
    req_wdata = wd;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      @(posedge clk); #1;
    end
    live   = (ts_m[addr] >= gt);
    e.op   = op;
    e.tag  = tag;
    e.data = mem_m[addr];
    e.tm   = live ? ts_m[addr] : gt;
    case (op)
      2'd0: begin
        e.tm = gt + 32'(pred_m);
        if (e.tm > ts_m[addr]) ts_m[addr] = e.tm;
        if (!live && pred_m < 255) pred_m++;
      end
      2'd1: begin
        mem_m[addr] = wd;
        if (live && pred_m > 1) pred_m--;
      end
      default: begin
        ts_m[addr] = '0;
        if (live && pred_m > 1) pred_m--;
      end
    endcase
    sb.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic idle();
    req_valid = 1'b0;
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 unexpected response", 32'(rsp_op), 32'hFFFFFFFF);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_op == e.op, {e.tag, " op"}, 32'(rsp_op), 32'(e.op));
          check(rsp_time == e.tm, {e.tag, " time"}, rsp_time, e.tm);
          if (e.op != 2'd1)
            check(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    for (int i = 0; i < 16; i++) begin ts_m[i] = '0; mem_m[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    @(posedge clk); #1;

    // R1 R2 R6: first load on lapsed block, grant G+16
    issue(2'd0, 1, 0, 100, "R1 R2 R6 first load");
    // R4 R5 R7: store to live block, not stalled
    issue(2'd1, 1, 32'hA5A5_0001, 105, "R4 R5 R7 live store");
    issue(2'd0, 1, 0, 106, "R2 R4 load after store");
    for (int i = 0; i < 10; i++)
      issue(2'd1, 1, 32'h100 + 32'(i), 107, "R7 live store dec");
    // R3: shorter grant leaves timestamp at the larger value
    issue(2'd0, 1, 0, 108, "R3 R6 short grant");
    issue(2'd1, 1, 32'h222, 109, "R3 R5 store sees max ts");
    // R11: ts equal to G is live
    issue(2'd1, 1, 32'h333, 122, "R11 R5 equal ts live");
    issue(2'd1, 1, 32'h444, 123, "R5 R7 lapsed store");
    // R8 evict
    issue(2'd0, 2, 0, 130, "R2 R6 load blk2");
    issue(2'd1, 2, 32'hBEEF, 131, "R4 store blk2");
    issue(2'd2, 2, 0, 131, "R8 live evict");
    issue(2'd1, 2, 32'hCAFE, 132, "R8 store after evict");
    issue(2'd0, 2, 0, 133, "R2 R8 load after evict");
    // R9 floor
    for (int i = 0; i < 12; i++)
      issue(2'd1, 2, 32'(i), 133, "R9 R7 floor store");
    issue(2'd0, 2, 0, 134, "R9 R6 floor live load");
    // R9 ceiling: many lapsed loads
    begin
      logic [31:0] g;
      g = 1000;
      for (int i = 0; i < 260; i++) begin
        issue(2'd0, 3, 0, g, "R9 R6 ceiling load");
        g = g + 300;
      end
    end
    idle();
    repeat (3) @(posedge clk); #1;

    // R10 back-pressure
    rsp_ready = 1'b0;
    issue(2'd0, 4, 0, 200000, "R10 held load");
    idle();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rsp_valid == 1'b1, "R10 rsp held valid", 32'(rsp_valid), 32'd1);
      check(req_ready == 1'b0, "R10 req_ready low", 32'(req_ready), 32'd0);
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    repeat (4) @(posedge clk);
    check(sb.size() == 0, "R10 queue drained", 32'(sb.size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule